// File: doc/BRIEF.md
# Single-Cycle 64-bit Load/Store Core

This block is a small processor core that retires one instruction per clock cycle. It supports eight instructions: immediate add, add and subtract with flag update, an unconditional branch, branch-if-register-zero, branch-if-signed-less-than, a 64-bit load and a 64-bit store. It holds a 32-entry register file whose last entry always reads as zero, a four-bit condition flag register, and a program counter. Branch targets are formed relative to the program counter.

Instruction fetch goes through a word-indexed port to a memory that sits outside the core. That memory answers combinationally. Data storage is a small array of 64-bit words inside the core. Loads read it without a clock edge, and stores write it at the clock edge. Two debug read ports bring out one register and one data word at any time, so that the effect of a program can be inspected once it has run.

A program usually ends in a branch to itself. The core then stays parked at that instruction with its state frozen, and the debug ports can be read at leisure.

Top module: `mini64_core`

## Requirements
- R1: An active-low reset clears the program counter, all registers, the flags and every data word to zero.
- R2: Immediate add (bits 31:22 = 1001000100) writes Rn plus the 12-bit field in bits 21:10, zero-extended, into Rd. Rn is in bits 9:5 and Rd is in bits 4:0.
- R3: Add-with-flags (bits 31:21 = 10101011000) and subtract-with-flags (bits 31:21 = 11101011000) write Rn+Rm or Rn−Rm into Rd, modulo 2^64. Rm is in bits 20:16.
- R4: Register index 31 always reads as zero. Writes to it are dropped, so an add or subtract that targets it only updates the flags.
- R5: Only add-with-flags and subtract-with-flags change the flags (N = result bit 63, Z, C, V = signed overflow). Branch-if-less (bits 31:24 = 01010100, bits 4:0 = 01011) is taken exactly when N differs from V. It sees the flags of the most recent flag-setting instruction, however many other instructions come between them.
- R6: The unconditional branch (bits 31:26 = 000101) moves the PC by the sign-extended bits 25:0 times four, in either direction. No instruction after a taken branch executes.
- R7: Branch-if-zero (bits 31:24 = 10110100) moves the PC by the sign-extended bits 23:5 times four when the register in bits 4:0 is zero. Otherwise it advances the PC by 4.
- R8: Load (bits 31:21 = 11111000010) and store (bits 31:21 = 11111000000) use the address Rn + sign-extended bits 20:12. The data word accessed is the one selected by the address bits above bit 2, so address 8 is word 1. The load writes the word into the register in bits 4:0, and the store writes that register into the word.
- R9: Any word that matches none of the encodings acts as a no-op that advances the PC by 4. This includes a conditional branch whose bits 4:0 are not 01011.
- R10: Every instruction that is not a taken branch advances the PC by exactly 4 in the cycle it executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | IMEM_AW | Word index of the instruction being fetched (PC bits above 1) |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| pc_o | output | XLEN | Current program counter |
| dbg_reg_sel | input | 5 | Register index for the debug read |
| dbg_reg_val | output | XLEN | Value of the selected register (zero for index 31) |
| dbg_mem_sel | input | log2(DMEM_WORDS) | Data word index for the debug read |
| dbg_mem_val | output | XLEN | Value of the selected data word |

## Verification
Each instruction commits its register, memory, flag and PC effects on the one rising edge of the cycle in which it is fetched. Both debug ports are combinational views of that committed state. An instruction's result can therefore be read half a cycle after its edge. The bench does not track individual edges. It lets each generated program run well past the longest path it can take, into its final self-branch, and then reads every result on the falling edge once the state has stopped changing. The only fixed timing the bench relies on is the single-cycle step of the PC, and the bound assertions check that step edge by edge.

// File: rtl/mini64_pkg.sv
package mini64_pkg;

    localparam int INSN_W = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [9:0]  OPC_ADDI  = 10'b1001000100;
    localparam logic [5:0]  OPC_B     = 6'b000101;
    localparam logic [7:0]  OPC_CBZ   = 8'b10110100;
    localparam logic [7:0]  OPC_BCOND = 8'b01010100;
    localparam logic [4:0]  COND_LT   = 5'b01011;
    localparam logic [10:0] OPC_ADDS  = 11'b10101011000;
    localparam logic [10:0] OPC_SUBS  = 11'b11101011000;
    localparam logic [10:0] OPC_LDUR  = 11'b11111000010;
    localparam logic [10:0] OPC_STUR  = 11'b11111000000;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_ADDI,
        OP_ADDS,
        OP_SUBS,
        OP_B,
        OP_CBZ,
        OP_BLT,
        OP_LDUR,
        OP_STUR
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        op_e               op;
        logic [RIDX_W-1:0] rd;   // destination, or data register of load/store
        logic [RIDX_W-1:0] rn;   // first source / base
        logic [RIDX_W-1:0] rb;   // second read port: Rm or Rt
    } dec_t;

endpackage

// File: rtl/mini64_decode.sv
module mini64_decode
    import mini64_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec,
    output logic [XLEN-1:0]   imm,
    output logic [XLEN-1:0]   br_off
);

    logic [XLEN-1:0] off_long;
    logic [XLEN-1:0] off_cond;
    logic [XLEN-1:0] imm_u12;
    logic [XLEN-1:0] imm_s9;

    assign off_long = {{(XLEN-28){insn[25]}}, insn[25:0], 2'b00};
    assign off_cond = {{(XLEN-21){insn[23]}}, insn[23:5], 2'b00};
    assign imm_u12  = {{(XLEN-12){1'b0}}, insn[21:10]};
    assign imm_s9   = {{(XLEN-9){insn[20]}}, insn[20:12]};

    always_comb begin
        dec.op = OP_NOP;
        dec.rd = insn[4:0];
        dec.rn = insn[9:5];
        dec.rb = insn[4:0];
        imm    = '0;
        br_off = '0;
        if (insn[31:22] == OPC_ADDI) begin
            dec.op = OP_ADDI;
            imm    = imm_u12;
        end else if (insn[31:26] == OPC_B) begin
            dec.op = OP_B;
            br_off = off_long;
        end else if (insn[31:24] == OPC_CBZ) begin
            dec.op = OP_CBZ;
            br_off = off_cond;
        end else if (insn[31:24] == OPC_BCOND && insn[4:0] == COND_LT) begin
            dec.op = OP_BLT;
            br_off = off_cond;
        end else if (insn[31:21] == OPC_ADDS) begin
            dec.op = OP_ADDS;
            dec.rb = insn[20:16];
        end else if (insn[31:21] == OPC_SUBS) begin
            dec.op = OP_SUBS;
            dec.rb = insn[20:16];
        end else if (insn[31:21] == OPC_LDUR) begin
            dec.op = OP_LDUR;
            imm    = imm_s9;
        end else if (insn[31:21] == OPC_STUR) begin
            dec.op = OP_STUR;
            imm    = imm_s9;
        end
    end

endmodule

// File: rtl/mini64_regfile.sv
module mini64_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREG)-1:0]  ra_addr,
    output logic [XLEN-1:0]          ra_data,
    input  logic [$clog2(NREG)-1:0]  rb_addr,
    output logic [XLEN-1:0]          rb_data,
    input  logic [$clog2(NREG)-1:0]  rc_addr,
    output logic [XLEN-1:0]          rc_data,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  wa,
    input  logic [XLEN-1:0]          wd
);

    localparam int AW = $clog2(NREG);
    localparam logic [AW-1:0] ZERO_IDX = AW'(NREG - 1);

    logic [XLEN-1:0] regs_q [NREG];
    logic [XLEN-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && wa != ZERO_IDX) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data = (ra_addr == ZERO_IDX) ? '0 : regs_q[ra_addr];
    assign rb_data = (rb_addr == ZERO_IDX) ? '0 : regs_q[rb_addr];
    assign rc_data = (rc_addr == ZERO_IDX) ? '0 : regs_q[rc_addr];

endmodule

// File: rtl/mini64_alu.sv
module mini64_alu
    import mini64_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] res,
    output flags_t          fl
);

    logic [XLEN-1:0] b_eff;
    logic [XLEN:0]   sum;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub};
        res   = sum[XLEN-1:0];
        fl.n  = res[XLEN-1];
        fl.z  = (res == '0);
        fl.c  = sum[XLEN];
        fl.v  = (a[XLEN-1] == b_eff[XLEN-1]) && (res[XLEN-1] != a[XLEN-1]);
    end

endmodule

// File: rtl/mini64_dmem.sv
module mini64_dmem #(
    parameter int XLEN  = 64,
    parameter int WORDS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(WORDS)-1:0]  addr,
    output logic [XLEN-1:0]           rdata,
    input  logic                      we,
    input  logic [XLEN-1:0]           wdata,
    input  logic [$clog2(WORDS)-1:0]  dbg_addr,
    output logic [XLEN-1:0]           dbg_data
);

    logic [XLEN-1:0] mem_q [WORDS];
    logic [XLEN-1:0] mem_d [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata    = mem_q[addr];
    assign dbg_data = mem_q[dbg_addr];

endmodule

// File: rtl/mini64_core.sv
module mini64_core
    import mini64_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int IMEM_AW    = 8,
    parameter int DMEM_WORDS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [IMEM_AW-1:0]            imem_addr,
    input  logic [INSN_W-1:0]             imem_data,
    output logic [XLEN-1:0]               pc_o,
    input  logic [RIDX_W-1:0]             dbg_reg_sel,
    output logic [XLEN-1:0]               dbg_reg_val,
    input  logic [$clog2(DMEM_WORDS)-1:0] dbg_mem_sel,
    output logic [XLEN-1:0]               dbg_mem_val
);

    localparam int DMEM_AW  = $clog2(DMEM_WORDS);
    localparam int WORD_LSB = $clog2(XLEN / 8);
    localparam int PC_LSB   = $clog2(INSN_W / 8);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(INSN_W / 8);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        flags_t          fl;
    } core_st_t;

    core_st_t st_q, st_d;

    dec_t              dec;
    logic [XLEN-1:0]   imm_x;
    logic [XLEN-1:0]   br_off;
    logic [XLEN-1:0]   ra_val;
    logic [XLEN-1:0]   rb_val;
    logic [XLEN-1:0]   alu_b;
    logic              alu_sub;
    logic [XLEN-1:0]   alu_res;
    flags_t            alu_fl;
    logic              rf_we;
    logic [XLEN-1:0]   rf_wdata;
    logic              dm_we;
    logic [XLEN-1:0]   dm_rdata;
    logic              br_taken;

    // named views for the bound checker
    flags_t            flags_cur;
    op_e               dec_op;
    logic [RIDX_W-1:0] rn_addr;
    logic [RIDX_W-1:0] rb_addr;

    assign imem_addr = st_q.pc[PC_LSB +: IMEM_AW];
    assign pc_o      = st_q.pc;
    assign flags_cur = st_q.fl;
    assign dec_op    = dec.op;
    assign rn_addr   = dec.rn;
    assign rb_addr   = dec.rb;

    mini64_decode #(.XLEN(XLEN)) u_dec (
        .insn   (imem_data),
        .dec    (dec),
        .imm    (imm_x),
        .br_off (br_off)
    );

    mini64_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (dec.rn),
        .ra_data (ra_val),
        .rb_addr (dec.rb),
        .rb_data (rb_val),
        .rc_addr (dbg_reg_sel),
        .rc_data (dbg_reg_val),
        .we      (rf_we),
        .wa      (dec.rd),
        .wd      (rf_wdata)
    );

    mini64_alu #(.XLEN(XLEN)) u_alu (
        .a   (ra_val),
        .b   (alu_b),
        .sub (alu_sub),
        .res (alu_res),
        .fl  (alu_fl)
    );

    mini64_dmem #(.XLEN(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (alu_res[WORD_LSB +: DMEM_AW]),
        .rdata    (dm_rdata),
        .we       (dm_we),
        .wdata    (rb_val),
        .dbg_addr (dbg_mem_sel),
        .dbg_data (dbg_mem_val)
    );

    // second ALU operand: register for the flag-setting ops, immediate otherwise
    always_comb begin : operand_sel
        alu_sub = (dec.op == OP_SUBS);
        alu_b   = (dec.op == OP_ADDS || dec.op == OP_SUBS) ? rb_val : imm_x;
    end

    always_comb begin : next_state
        st_d     = st_q;
        rf_we    = 1'b0;
        rf_wdata = alu_res;
        dm_we    = 1'b0;
        br_taken = 1'b0;
        unique case (dec.op)
            OP_ADDI: rf_we = 1'b1;
            OP_ADDS, OP_SUBS: begin
                rf_we   = 1'b1;
                st_d.fl = alu_fl;
            end
            OP_LDUR: begin
                rf_we    = 1'b1;
                rf_wdata = dm_rdata;
            end
            OP_STUR: dm_we = 1'b1;
            OP_B:    br_taken = 1'b1;
            OP_CBZ:  br_taken = (rb_val == '0);
            OP_BLT:  br_taken = (st_q.fl.n != st_q.fl.v);
            default: ;
        endcase
        st_d.pc = br_taken ? (st_q.pc + br_off) : (st_q.pc + PC_STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mini64_core_chk.sv
module mini64_core_chk
    import mini64_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   pc_q,
    input op_e               op,
    input logic              br_taken,
    input flags_t            flags_q,
    input logic [RIDX_W-1:0] ra_addr,
    input logic [XLEN-1:0]   ra_data,
    input logic [RIDX_W-1:0] rb_addr,
    input logic [XLEN-1:0]   rb_data
);

    localparam logic [XLEN-1:0]   STEP  = XLEN'(4);
    localparam logic [RIDX_W-1:0] ZIDX  = RIDX_W'(NREG - 1);

    AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> (pc_q == '0)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |=> (pc_q == $past(pc_q) + STEP)); // R10

    AST_PC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00); // R6

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(op == OP_ADDS || op == OP_SUBS) |=> $stable(flags_q)); // R5

    AST_BLT_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BLT && flags_q.n == flags_q.v) |=> (pc_q == $past(pc_q) + STEP)); // R5

    AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr == ZIDX) |-> (ra_data == '0)); // R4

    AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_addr == ZIDX) |-> (rb_data == '0)); // R4

    AST_CBZ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CBZ && rb_data != '0) |=> (pc_q == $past(pc_q) + STEP)); // R7

endmodule

bind mini64_core mini64_core_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_q     (pc_o),
    .op       (dec_op),
    .br_taken (br_taken),
    .flags_q  (flags_cur),
    .ra_addr  (rn_addr),
    .ra_data  (ra_val),
    .rb_addr  (rb_addr),
    .rb_data  (rb_val)
);

// File: tb/mini64_core_test.sv
`timescale 1ns/1ps
module mini64_core_test;

    localparam int XLEN       = 64;
    localparam int IMEM_AW    = 8;
    localparam int DMEM_WORDS = 16;
    localparam int DMEM_AW    = $clog2(DMEM_WORDS);
    localparam int RUN_CYCLES = 250;
    localparam logic [63:0] VMIN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] VMAX = 64'h7FFF_FFFF_FFFF_FFFF;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [IMEM_AW-1:0] imem_addr;
    logic [31:0]        imem_data;
    logic [XLEN-1:0]    pc_o;
    logic [4:0]         dbg_reg_sel = '0;
    logic [XLEN-1:0]    dbg_reg_val;
    logic [DMEM_AW-1:0] dbg_mem_sel = '0;
    logic [XLEN-1:0]    dbg_mem_val;

    logic [31:0] prog [1 << IMEM_AW];
    int wp;
    int n_checks = 0;
    int n_errs = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    assign imem_data = prog[imem_addr];

    mini64_core #(.XLEN(XLEN), .IMEM_AW(IMEM_AW), .DMEM_WORDS(DMEM_WORDS)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .imem_addr   (imem_addr),
        .imem_data   (imem_data),
        .pc_o        (pc_o),
        .dbg_reg_sel (dbg_reg_sel),
        .dbg_reg_val (dbg_reg_val),
        .dbg_mem_sel (dbg_mem_sel),
        .dbg_mem_val (dbg_mem_val)
    );

    // ---------------- encoders ----------------
    function automatic logic [31:0] e_addi(input int rd, input int rn, input int imm);
        logic [11:0] i12 = imm[11:0];
        return {10'b1001000100, i12, rn[4:0], rd[4:0]};
    endfunction
    function automatic logic [31:0] e_rr(input bit sub, input int rd, input int rn, input int rm);
        return {(sub ? 11'b11101011000 : 11'b10101011000), rm[4:0], 6'b0, rn[4:0], rd[4:0]};
    endfunction
    function automatic logic [31:0] e_b(input int off);
        logic [31:0] o = off;
        return {6'b000101, o[25:0]};
    endfunction
    function automatic logic [31:0] e_cbz(input int off, input int rt);
        logic [31:0] o = off;
        return {8'b10110100, o[18:0], rt[4:0]};
    endfunction
    function automatic logic [31:0] e_bcond(input int off, input logic [4:0] cond);
        logic [31:0] o = off;
        return {8'b01010100, o[18:0], cond};
    endfunction
    function automatic logic [31:0] e_mem(input bit load, input int rt, input int rn, input int imm);
        logic [31:0] i = imm;
        return {(load ? 11'b11111000010 : 11'b11111000000), i[8:0], 2'b00, rn[4:0], rt[4:0]};
    endfunction

    task automatic emit(input logic [31:0] w);
        prog[wp] = w;
        wp++;
    endtask

    task automatic load_val(input int rd, input logic [63:0] v);
        if (v == VMIN || v == VMAX) begin
            emit(e_addi(rd, 31, 1));
            for (int i = 0; i < 63; i++) emit(e_rr(1'b0, rd, rd, rd));
            if (v == VMAX) emit(e_rr(1'b1, rd, rd, 20));
        end else if (!v[63]) begin
            emit(e_addi(rd, 31, int'(v)));
        end else begin
            emit(e_addi(rd, 31, int'(-v)));
            emit(e_rr(1'b1, rd, 31, rd));
        end
    endtask

    function automatic logic [63:0] val_of(input int i);
        case (i)
            0: return 64'd0;
            1: return 64'd1;
            2: return 64'd7;
            3: return -64'sd1;
            4: return -64'sd3;
            5: return 64'd4095;
            6: return VMAX;
            default: return VMIN;
        endcase
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd_reg(input int r, output logic [63:0] v);
        dbg_reg_sel = r[4:0];
        #1;
        v = dbg_reg_val;
    endtask

    task automatic rd_mem(input int w, output logic [63:0] v);
        dbg_mem_sel = w[DMEM_AW-1:0];
        #1;
        v = dbg_mem_val;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog expired before the sweep finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    // ---------------- main sweep ----------------
    initial begin
        logic [63:0] v;
        logic [63:0] a, b;
        logic [64:0] s65;
        int halt_idx, k;

        for (int i = 0; i < (1 << IMEM_AW); i++) prog[i] = e_b(0);

        // R1: state after reset, before any instruction executes
        hold_reset();
        chk("R1", "pc after reset", pc_o, 64'd0);
        for (int r = 0; r < 32; r++) begin
            rd_reg(r, v);
            chk("R1", $sformatf("reg %0d after reset", r), v, 64'd0);
        end
        for (int w = 0; w < DMEM_WORDS; w++) begin
            rd_mem(w, v);
            chk("R1", $sformatf("data word %0d after reset", w), v, 64'd0);
        end

        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                a = val_of(ia);
                b = val_of(ib);
                for (int i = 0; i < (1 << IMEM_AW); i++) prog[i] = e_b(0);
                wp = 0;
                emit(e_addi(20, 31, 1));
                load_val(1, a);
                load_val(2, b);
                emit(e_addi(31, 31, 5));            // dropped write (R4)
                emit(e_addi(6, 31, 0));
                emit(e_rr(1'b1, 3, 1, 2));          // X3 = a-b
                emit(e_rr(1'b0, 4, 1, 2));          // X4 = a+b
                emit(e_rr(1'b1, 31, 1, 2));         // flags of a-b only
                emit(e_addi(7, 31, 4095));          // zero-extended imm (R2)
                emit(e_mem(1'b0, 2, 31, 8));        // word1 = b
                emit(e_addi(13, 31, 24));
                emit(e_mem(1'b0, 4, 13, -8));       // word2 = a+b
                emit(e_mem(1'b1, 14, 13, -16));     // X14 = word1
                emit(32'h0000_0000);                // unknown word (R9)
                emit(e_bcond(2, 5'b00000));         // other condition: no-op (R9)
                emit(e_addi(17, 31, 1));
                emit(e_bcond(2, 5'b01011));         // taken iff a<b
                emit(e_addi(5, 31, 1));
                emit(e_rr(1'b0, 31, 1, 2));         // flags of a+b
                emit(e_bcond(2, 5'b01011));         // taken iff a+b<0
                emit(e_addi(18, 31, 1));
                emit(e_cbz(2, 1));                  // taken iff a==0
                emit(e_addi(12, 31, 1));
                k = wp;
                emit(e_b(3));                       // k   -> k+3
                emit(e_addi(15, 31, 9));            // k+1
                emit(e_b(2));                       // k+2 -> k+4
                emit(e_b(-2));                      // k+3 -> k+1
                emit(e_addi(16, 31, 2));            // k+4
                halt_idx = wp;
                emit(e_b(0));                       // k+5 park
                if (halt_idx != k + 5) $display("bench layout mismatch");

                hold_reset();
                rst_n = 1'b1;
                repeat (RUN_CYCLES) @(posedge clk);
                @(negedge clk);

                s65 = {a[63], a} + {b[63], b};
                rd_reg(1, v);  chk("R3", "operand a", v, a);
                rd_reg(3, v);  chk("R3", "a-b", v, a - b);
                rd_reg(4, v);  chk("R3", "a+b", v, a + b);
                rd_reg(6, v);  chk("R4", "read after write to x31", v, 64'd0);
                rd_reg(31, v); chk("R4", "x31 debug read", v, 64'd0);
                rd_reg(7, v);  chk("R2", "imm 4095 zero-extended", v, 64'd4095);
                rd_reg(5, v);  chk("R5", "less-than after sub", v, ($signed(a) < $signed(b)) ? 64'd0 : 64'd1);
                rd_reg(18, v); chk("R5", "less-than after add", v, s65[64] ? 64'd0 : 64'd1);
                rd_mem(1, v);  chk("R8", "store at address 8", v, b);
                rd_mem(2, v);  chk("R8", "store with negative offset", v, a + b);
                rd_reg(14, v); chk("R8", "load with negative offset", v, b);
                rd_reg(12, v); chk("R7", "branch-if-zero", v, (a == 64'd0) ? 64'd0 : 64'd1);
                rd_reg(15, v); chk("R6", "backward branch target", v, 64'd9);
                rd_reg(16, v); chk("R6", "forward branch skip", v, 64'd2);
                rd_reg(17, v); chk("R9", "no-op words fall through", v, 64'd1);
                chk("R6", "parked pc", pc_o, 64'(halt_idx * 4));
            end
        end

        // R1: reset after activity clears state again
        hold_reset();
        chk("R1", "pc after second reset", pc_o, 64'd0);
        rd_reg(3, v);  chk("R1", "reg 3 after second reset", v, 64'd0);
        rd_mem(1, v);  chk("R1", "word 1 after second reset", v, 64'd0);
        rd_mem(2, v);  chk("R1", "word 2 after second reset", v, 64'd0);

        // R10: straight-line stepping, one instruction per cycle
        for (int i = 0; i < (1 << IMEM_AW); i++) prog[i] = e_addi(9, 9, 1);
        rst_n = 1'b1;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            chk("R10", $sformatf("pc after %0d cycles", c), pc_o, 64'(c * 4));
        end
        rd_reg(9, v); chk("R10", "one increment per cycle", v, 64'd5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule